// File: doc/BRIEF.md
# Indirect-Access Connection Memory Loader

This block is the host-facing register front end of a time-slot switch's connection memory. The host has two locations. One is an address register that selects an internal location. The other is a data port that reads or writes the selected location. Four holding bytes stage one connection entry:

- the time-slot number,
- a control/stream byte,
- the data-memory tag (the data RAM location that keeps the switched sample),
- one spare byte.

To store the entry, the host writes a command code into the address register and then writes the same value through the data port. Storing the entry is one such command. The entry goes into the lowest-numbered free location of a 16-entry connection memory. Each entry has a valid bit.

A busy flag covers a short fixed window after each store. During that window, staging writes and further stores are refused. Two more commands clear the overflow flag or clear the whole memory. Status, the valid count and every stored byte can be read back through the data port. The switching datapath itself is not part of this block.

Top module: `cam_conn_loader`

## Requirements
- R1: While `rst` is high, at the next edge `rdata` becomes 0x00, `cam_busy` goes low, the address register clears to 0x00, every valid bit and the overflow flag clear.
- R2: A write with `sel`=0 loads `wdata` into the address register. A read with `sel`=0 returns that value on `rdata` one cycle after `rd_en`.
- R3: A data write (`sel`=1) while the address register holds 0xB0, 0xB1, 0xB2 or 0xB3 stores the byte in that holding register, and a data read returns it. 0xB0 holds the time slot. 0xB1 holds the control byte: bit 7 is the direction toward the local pins, bit 6 enables pattern mode, bit 5 selects non-minimum delay, bits 4:0 are the stream. 0xB2 holds the tag and 0xB3 the spare byte.
- R4: A data write whose value equals an address register value of 0xE3 copies the four holding bytes into the lowest-numbered entry with a clear valid bit and sets that bit. Byte k (k = 0 time slot, 1 control, 2 tag, 3 spare) of entry n reads back at internal address 0x40 + 4n + k.
- R5: A data write whose value differs from the address register, or whose value equals it when that value is not a command code, is an ordinary register write. No command executes and the valid count does not change.
- R6: `cam_busy`, also bit 0 of the status byte at internal address 0x00, is high for exactly 4 cycles after the edge that accepts a store. It is low otherwise.
- R7: While `cam_busy` is high, data writes to the holding registers and store commands are ignored. The first write after busy falls is accepted.
- R8: A store command while all 16 valid bits are set writes nothing. It sets the overflow flag (status bit 1) and does not raise `cam_busy`.
- R9: Command 0x70 (written twice) clears the overflow flag only. Command 0xF8 (written twice) clears all valid bits and the overflow flag.
- R10: Internal address 0x01 reads the number of valid entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; `rdata` updates at the next edge |
| sel | input | 1 | 0 selects the address register, 1 selects the data port |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| cam_busy | output | 1 | High while a store's busy window is open |

## Verification
Two functions can meet in the same edge: a staging write or a second store can arrive while the busy window of the previous store is closing. The bench issues a repeated store one cycle after an accepted store. It then places a holding-register write exactly on the last busy edge, and in a second run one edge later. After each run it reads the holding byte and the valid count back. The write on the last busy edge must leave the old value and the count. The write one edge later must take effect. Every cycle of the window is also sampled on `cam_busy` against the expected four-cycle shape.

// File: rtl/cam_ld_pkg.sv
package cam_ld_pkg;
  localparam logic [7:0] ADR_STATUS  = 8'h00;
  localparam logic [7:0] ADR_COUNT   = 8'h01;
  localparam logic [7:0] ADR_SLOT    = 8'hB0;
  localparam logic [7:0] VIEW_BASE   = 8'h40;
  localparam logic [7:0] CMD_STORE   = 8'hE3;
  localparam logic [7:0] CMD_CLR_ERR = 8'h70;
  localparam logic [7:0] CMD_CLR_ALL = 8'hF8;

  function automatic logic is_cmd_code(input logic [7:0] v);
    return (v == CMD_STORE) || (v == CMD_CLR_ERR) || (v == CMD_CLR_ALL);
  endfunction
endpackage

// File: rtl/cam_free_pick.sv
module cam_free_pick #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] valid,
  output logic [IDX_W-1:0] free_idx,
  output logic             any_free
);
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_entry_store.sv
module cam_entry_store #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [ENT_W-1:0] wentry,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] ridx,
  output logic [ENT_W-1:0] rentry,
  output logic [DEPTH-1:0] valid
);
  logic [ENT_W-1:0] mem [DEPTH];

  // entry array without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wentry;
  end

  assign rentry = mem[ridx];

  always_ff @(posedge clk) begin
    if (rst || clr_all) valid <= '0;
    else if (we)        valid[widx] <= 1'b1;
  end
endmodule

// File: rtl/cam_busy_timer.sv
module cam_busy_timer #(
  parameter int CYC = 4,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/cam_conn_loader.sv
module cam_conn_loader
  import cam_ld_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int BUSY_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       cam_busy
);
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int CNT_W    = IDX_W + 1;
  localparam int VIEW_END = int'(VIEW_BASE) + 4 * DEPTH;

  logic [7:0]       addr_q;
  logic [3:0][7:0]  hold_q;
  logic             err_q;
  logic [DEPTH-1:0] valid;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic [31:0]      ent_rd;
  logic [7:0]       view_off;
  logic [IDX_W-1:0] view_idx;
  logic [CNT_W-1:0] vcnt;
  logic [7:0]       loc_val;

  logic data_wr, cmd_hit, store_go, store_full, clr_all, clr_err, hold_wr;

  assign data_wr    = wr_en && sel;
  assign cmd_hit    = data_wr && (wdata == addr_q) && is_cmd_code(addr_q);
  assign store_go   = cmd_hit && (addr_q == CMD_STORE) && !cam_busy && any_free;
  assign store_full = cmd_hit && (addr_q == CMD_STORE) && !cam_busy && !any_free;
  assign clr_all    = cmd_hit && (addr_q == CMD_CLR_ALL);
  assign clr_err    = cmd_hit && ((addr_q == CMD_CLR_ERR) || (addr_q == CMD_CLR_ALL));
  assign hold_wr    = data_wr && !cmd_hit && !cam_busy
                      && (addr_q[7:2] == ADR_SLOT[7:2]);

  cam_free_pick #(.DEPTH(DEPTH)) u_pick (
    .valid    (valid),
    .free_idx (free_idx),
    .any_free (any_free)
  );

  cam_entry_store #(.DEPTH(DEPTH), .ENT_W(32)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (store_go),
    .widx    (free_idx),
    .wentry  (hold_q),
    .clr_all (clr_all),
    .ridx    (view_idx),
    .rentry  (ent_rd),
    .valid   (valid)
  );

  cam_busy_timer #(.CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (store_go),
    .busy  (cam_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      hold_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && !sel) addr_q <= wdata;
      if (hold_wr)       hold_q[addr_q[1:0]] <= wdata;
      if (store_full)    err_q <= 1'b1;
      else if (clr_err)  err_q <= 1'b0;
    end
  end

  always_comb begin
    vcnt = '0;
    for (int i = 0; i < DEPTH; i++) vcnt = vcnt + CNT_W'(valid[i]);
  end

  assign view_off = addr_q - VIEW_BASE;
  assign view_idx = IDX_W'(view_off >> 2);

  always_comb begin
    loc_val = '0;
    if (addr_q >= VIEW_BASE && int'(addr_q) < VIEW_END) begin
      loc_val = ent_rd[{addr_q[1:0], 3'b000} +: 8];
    end else if (addr_q[7:2] == ADR_SLOT[7:2]) begin
      loc_val = hold_q[addr_q[1:0]];
    end else if (addr_q == ADR_STATUS) begin
      loc_val = {6'b0, err_q, cam_busy};
    end else if (addr_q == ADR_COUNT) begin
      loc_val = 8'(vcnt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel ? loc_val : addr_q;
  end
endmodule

// File: rtl/cam_conn_loader_chk.sv
module cam_conn_loader_chk
  import cam_ld_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             sel,
  input logic [7:0]       wdata,
  input logic [7:0]       addr_q,
  input logic [3:0][7:0]  hold_q,
  input logic [DEPTH-1:0] valid,
  input logic             err_q,
  input logic             cam_busy,
  input logic [7:0]       rdata
);
  logic store_cmd;
  assign store_cmd = wr_en && sel && addr_q == CMD_STORE && wdata == CMD_STORE;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (rdata == 8'h00 && !cam_busy && valid == '0 && !err_q && addr_q == 8'h00));

  assert_store_adds_one_R4: assert property (@(posedge clk) disable iff (rst)
    (store_cmd && !cam_busy && !(&valid)) |=>
      ($countones(valid) == $past($countones(valid)) + 1));

  assert_mismatch_no_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && wdata != addr_q) |=> $stable(valid));

  assert_busy_after_store_R6: assert property (@(posedge clk) disable iff (rst)
    (store_cmd && !cam_busy && !(&valid)) |=> cam_busy);

  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && cam_busy && addr_q[7:2] == ADR_SLOT[7:2]) |=> $stable(hold_q));

  assert_full_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (store_cmd && !cam_busy && (&valid)) |=> (err_q && $stable(valid) && !cam_busy));

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && addr_q == CMD_CLR_ALL && wdata == CMD_CLR_ALL) |=>
      (valid == '0 && !err_q));
endmodule

bind cam_conn_loader cam_conn_loader_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .sel      (sel),
  .wdata    (wdata),
  .addr_q   (addr_q),
  .hold_q   (hold_q),
  .valid    (valid),
  .err_q    (err_q),
  .cam_busy (cam_busy),
  .rdata    (rdata)
);

// File: tb/cam_conn_loader_tb.sv
module cam_conn_loader_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic cam_busy;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cam_conn_loader u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .rdata(rdata), .cam_busy(cam_busy)
  );

  localparam logic [1:0] OP_AW = 2'd0, OP_DW = 2'd1, OP_AR = 2'd2, OP_DR = 2'd3;
  localparam int NV = 36;
  // {op, value, expected, requirement number}
  localparam logic [21:0] VEC [NV] = '{
    {OP_AW, 8'hB0, 8'h00, 4'd2},   // R2
    {OP_AR, 8'h00, 8'hB0, 4'd2},   // R2 address readback
    {OP_DW, 8'h1D, 8'h00, 4'd3},   // R3 time slot 29
    {OP_DR, 8'h00, 8'h1D, 4'd3},
    {OP_AW, 8'hB1, 8'h00, 4'd3},
    {OP_DW, 8'h83, 8'h00, 4'd3},   // R3 direction bit + stream 3
    {OP_DR, 8'h00, 8'h83, 4'd3},
    {OP_AW, 8'hB2, 8'h00, 4'd3},
    {OP_DW, 8'h31, 8'h00, 4'd3},   // R3 tag 49
    {OP_AW, 8'hB3, 8'h00, 4'd3},
    {OP_DW, 8'hA5, 8'h00, 4'd3},
    {OP_DR, 8'h00, 8'hA5, 4'd3},
    {OP_AW, 8'hB2, 8'h00, 4'd3},
    {OP_DR, 8'h00, 8'h31, 4'd3},
    {OP_AW, 8'hB0, 8'h00, 4'd5},
    {OP_DW, 8'hB0, 8'h00, 4'd5},   // R5 equal value, not a command
    {OP_DR, 8'h00, 8'hB0, 4'd5},
    {OP_DW, 8'h1D, 8'h00, 4'd3},
    {OP_AW, 8'hE3, 8'h00, 4'd5},
    {OP_DW, 8'h5A, 8'h00, 4'd5},   // R5 mismatch, no store
    {OP_AW, 8'h01, 8'h00, 4'd5},
    {OP_DR, 8'h00, 8'h00, 4'd5},
    {OP_AW, 8'hE3, 8'h00, 4'd4},
    {OP_DW, 8'hE3, 8'h00, 4'd4},   // R4 store into entry 0
    {OP_AW, 8'h01, 8'h00, 4'd10},
    {OP_DR, 8'h00, 8'h01, 4'd10},  // R10 count
    {OP_AW, 8'h40, 8'h00, 4'd4},
    {OP_DR, 8'h00, 8'h1D, 4'd4},
    {OP_AW, 8'h41, 8'h00, 4'd4},
    {OP_DR, 8'h00, 8'h83, 4'd4},
    {OP_AW, 8'h42, 8'h00, 4'd4},
    {OP_DR, 8'h00, 8'h31, 4'd4},
    {OP_AW, 8'h43, 8'h00, 4'd4},
    {OP_DR, 8'h00, 8'hA5, 4'd4},
    {OP_AW, 8'h00, 8'h00, 4'd6},
    {OP_DR, 8'h00, 8'h00, 4'd6}    // R6 idle status
  };

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; sel = s; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; sel = s;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic rdloc(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    wr(1'b0, a);
    rd(1'b1, v);
    chk(v, exp, req);
  endtask

  task automatic do_store();
    wr(1'b0, 8'hE3);
    wr(1'b1, 8'hE3);
  endtask

  task automatic wait_idle();
    while (cam_busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rdata, 8'h00, "R1 rdata");
    chk({7'b0, cam_busy}, 8'h00, "R1 busy");
    rd(1'b0, v); chk(v, 8'h00, "R1 address reg");
    rdloc(8'h00, 8'h00, "R1 status");
    rdloc(8'h01, 8'h00, "R1 count");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][21:20];
      case (op)
        OP_AW: wr(1'b0, VEC[i][19:12]);
        OP_DW: wr(1'b1, VEC[i][19:12]);
        OP_AR: begin rd(1'b0, v); chk(v, VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i)); end
        default: begin rd(1'b1, v); chk(v, VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i)); end
      endcase
    end

    // R6: exact busy window shape, store into entry 1
    wait_idle();
    do_store();
    chk({7'b0, cam_busy}, 8'h01, "R6 busy cycle 1");
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk({7'b0, cam_busy}, 8'h01, $sformatf("R6 busy cycle %0d", k));
    end
    @(negedge clk);
    chk({7'b0, cam_busy}, 8'h00, "R6 busy released");

    // R7: repeated store and holding write on last busy edge are ignored (entry 2)
    wait_idle();
    do_store();
    wr_en = 1'b1; sel = 1'b1; wdata = 8'hE3;      // second store while busy
    @(negedge clk); sel = 1'b0; wdata = 8'hB0;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); wr_en = 1'b1; sel = 1'b1; wdata = 8'h55;  // last busy edge
    @(negedge clk); wr_en = 1'b0;
    wait_idle();
    rdloc(8'hB0, 8'h1D, "R7 hold write on last busy edge");
    rdloc(8'h01, 8'h03, "R7 store during busy");

    // R7: write one edge after busy ends is taken (entry 3)
    do_store();
    wr_en = 1'b1; sel = 1'b0; wdata = 8'hB0;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; sel = 1'b1; wdata = 8'h66;
    @(negedge clk); wr_en = 1'b0;
    rdloc(8'hB0, 8'h66, "R7 hold write after busy");
    rdloc(8'h01, 8'h04, "R10 count after four stores");

    // R8: fill the memory, then overflow
    for (int k = 0; k < 12; k++) begin
      wait_idle();
      do_store();
    end
    wait_idle();
    rdloc(8'h01, 8'h10, "R10 full count");
    rdloc(8'h7C, 8'h66, "R4 last entry slot byte");
    do_store();
    chk({7'b0, cam_busy}, 8'h00, "R8 no busy on overflow");
    rdloc(8'h00, 8'h02, "R8 overflow flag");
    rdloc(8'h01, 8'h10, "R8 count unchanged");

    // R9: clear-flag and clear-all commands
    wr(1'b0, 8'h70); wr(1'b1, 8'h70);
    rdloc(8'h00, 8'h00, "R9 flag cleared");
    rdloc(8'h01, 8'h10, "R9 entries kept");
    do_store();
    wr(1'b0, 8'hF8); wr(1'b1, 8'hF8);
    rdloc(8'h00, 8'h00, "R9 clear-all flag");
    rdloc(8'h01, 8'h00, "R9 clear-all count");

    // R4: after clearing, the store lands in entry 0 again
    do_store();
    wait_idle();
    rdloc(8'h40, 8'h66, "R4 lowest free entry");
    rdloc(8'h01, 8'h01, "R10 count after refill");

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    chk(rdata, 8'h00, "R1 rdata after reset");
    rd(1'b0, v); chk(v, 8'h00, "R1 address after reset");
    rdloc(8'h01, 8'h00, "R1 count after reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule